// File: doc/BRIEF.md
# Streaming Ethernet and IPv4 Header Parser

This block watches a byte stream, one byte per clock when the input strobe is high, with flags that mark the first and last byte of each packet. It copies the 14-byte Ethernet header into a header record. If the 16-bit type field selects IPv4, it goes on to copy the 20-byte option-less IPv4 header into the same record. Each header in the record has its own valid flag. Once the parse decision is known, a one-cycle done pulse presents the record, an accept or reject outcome and an error code.

Bytes that follow an accepted IPv4 header are forwarded as payload one cycle later. A packet that is rejected is drained silently up to its last byte. All multi-byte fields are assembled most significant byte first.

The parser is meant to sit at the front of a packet pipeline. The stages behind it read the header fields while done is high, or at any time until the next start of packet.

Top module: `hdrparse_top`

## Requirements
- R1: After reset, done, eth_valid, ip_valid and pay_valid are all low.
- R2: Packet bytes 0 to 5 form eth_dst, bytes 6 to 11 form eth_src and bytes 12 to 13 form eth_type, with the first byte of each field in its most significant position. eth_valid rises in the cycle after byte 13 is taken.
- R3: When eth_type equals 16'h0800, bytes 14 to 33 are taken as the IPv4 header, each field filled MSB first in this fixed bit order:
  - version (4 bits) and ihl (4 bits) come from byte 14;
  - then tos (8), total length (16), identification (16), flags (3), fragment offset (13), ttl (8), protocol (8), checksum (16), source address (32) and destination address (32).
  - In the cycle after byte 33, done pulses with res_accept = 1, err_code = 0, and both eth_valid and ip_valid set.
- R4: When eth_type is any other value, done pulses in the cycle after byte 13 with res_accept = 0 and err_code = 2 (parse error). eth_valid is then 1 and ip_valid is 0.
- R5: When the last byte of a packet comes before the header being extracted is complete, done pulses in the cycle after that byte with res_accept = 0 and err_code = 1 (too short). eth_valid is 1 only if all 14 Ethernet bytes were taken, and ip_valid is 0. The value 3 is never reported.
- R6: done lasts exactly one cycle per packet. res_accept and err_code change only in a cycle where done is high. The header fields hold their values after done until the next start of packet.
- R7: A start-of-packet byte clears both valid flags and becomes byte 0 of a new packet, even when the previous packet is still being parsed. An abandoned packet gives no done pulse.
- R8: For an accepted packet, each byte after byte 33 appears on pay_data with pay_valid one cycle after it is taken, and pay_eop marks the packet's last byte. A rejected packet gives no payload.
- R9: Bytes that arrive between packets without a start flag are ignored. They produce no done pulse and no payload.
- R10: Cycles with in_valid low stall the parse without changing its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| done | output | 1 | One-cycle result pulse |
| res_accept | output | 1 | 1 accept, 0 reject |
| err_code | output | 2 | 0 none, 1 too short, 2 parse error |
| eth_valid | output | 1 | Ethernet header extracted |
| eth_dst | output | 48 | Destination address |
| eth_src | output | 48 | Source address |
| eth_type | output | 16 | Type field |
| ip_valid | output | 1 | IPv4 header extracted |
| ip_ver | output | 4 | Version |
| ip_ihl | output | 4 | Header length |
| ip_tos | output | 8 | Type of service |
| ip_tlen | output | 16 | Total length |
| ip_id | output | 16 | Identification |
| ip_flags | output | 3 | Flags |
| ip_frag | output | 13 | Fragment offset |
| ip_ttl | output | 8 | Time to live |
| ip_proto | output | 8 | Protocol |
| ip_csum | output | 16 | Header checksum |
| ip_src | output | 32 | Source address |
| ip_dst | output | 32 | Destination address |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pay_eop | output | 1 | Last payload byte |

## Verification
The properties treat in_sop and in_eop as meaningful only while in_valid is high. They also assume that every packet the upstream source intends to finish does end with an end flag. The bench keeps to these rules:
- it raises the flags only on strobed bytes;
- it idles for at least one cycle between packets, so done pulses cannot be adjacent;
- it leaves a packet unfinished only when it then opens a new one on purpose, to exercise the restart rule.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int ETH_BYTES = 14;
  localparam int IP_BYTES  = 20;
  localparam int HDR_BYTES = ETH_BYTES + IP_BYTES;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ETH,
    ST_IP,
    ST_PAY,
    ST_DRAIN
  } pstate_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SHORT = 2'd1,
    ERR_PARSE = 2'd2
  } perr_t;
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter logic [15:0] ETYPE_IP = 16'h0800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       type_hi,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic             pay_fire,
  output logic             done_q,
  output logic             acc_q,
  output logic [1:0]       err_q,
  output logic             ev_q,
  output logic             iv_q
);
  localparam logic [CNT_W-1:0] ETH_LAST = CNT_W'(ETH_BYTES - 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);

  pstate_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d, acc_d, ev_d, iv_d;
  logic [1:0]       err_d;
  logic             type_ok;

  assign type_ok = ({type_hi, in_data} == ETYPE_IP);
  assign wr_idx  = in_sop ? '0 : cnt_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    acc_d    = acc_q;
    err_d    = err_q;
    ev_d     = ev_q;
    iv_d     = iv_q;
    wr_en    = 1'b0;
    pay_fire = 1'b0;
    if (in_valid && in_sop) begin
      ev_d  = 1'b0;
      iv_d  = 1'b0;
      wr_en = 1'b1;
      cnt_d = CNT_W'(1);
      if (in_eop) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        acc_d  = 1'b0;
        err_d  = ERR_SHORT;
      end else begin
        st_d = ST_ETH;
      end
    end else if (in_valid) begin
      unique case (st_q)
        ST_ETH: begin
          wr_en = 1'b1;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == ETH_LAST) begin
            ev_d = 1'b1;
            if (!type_ok) begin
              done_d = 1'b1;
              acc_d  = 1'b0;
              err_d  = ERR_PARSE;
              st_d   = in_eop ? ST_IDLE : ST_DRAIN;
            end else if (in_eop) begin
              done_d = 1'b1;
              acc_d  = 1'b0;
              err_d  = ERR_SHORT;
              st_d   = ST_IDLE;
            end else begin
              st_d = ST_IP;
            end
          end else if (in_eop) begin
            done_d = 1'b1;
            acc_d  = 1'b0;
            err_d  = ERR_SHORT;
            st_d   = ST_IDLE;
          end
        end
        ST_IP: begin
          wr_en = 1'b1;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == HDR_LAST) begin
            iv_d   = 1'b1;
            done_d = 1'b1;
            acc_d  = 1'b1;
            err_d  = ERR_NONE;
            st_d   = in_eop ? ST_IDLE : ST_PAY;
          end else if (in_eop) begin
            done_d = 1'b1;
            acc_d  = 1'b0;
            err_d  = ERR_SHORT;
            st_d   = ST_IDLE;
          end
        end
        ST_PAY: begin
          pay_fire = 1'b1;
          if (in_eop) st_d = ST_IDLE;
        end
        ST_DRAIN: begin
          if (in_eop) st_d = ST_IDLE;
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ev_q   <= 1'b0;
      iv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ev_q   <= ev_d;
      iv_q   <= iv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      err_q <= ERR_NONE;
    end else if (done_d) begin
      acc_q <= acc_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/hp_store.sv
module hp_store
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [HDR_W-1:0] hdr
);
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    assign hit = wr_en && (wr_idx == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data;
    end
    assign hdr[HDR_W-1-8*i -: 8] = byte_q;
  end
endmodule

// File: rtl/hp_pass.sv
module hp_pass (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] data,
  input  logic       eop,
  output logic       pay_valid,
  output logic [7:0] pay_data,
  output logic       pay_eop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pay_valid <= 1'b0;
    else        pay_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_data <= '0;
      pay_eop  <= 1'b0;
    end else if (fire) begin
      pay_data <= data;
      pay_eop  <= eop;
    end
  end
endmodule

// File: rtl/hdrparse_top.sv
module hdrparse_top
  import hp_pkg::*;
#(
  parameter logic [15:0] ETYPE_IP = 16'h0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        done,
  output logic        res_accept,
  output logic [1:0]  err_code,
  output logic        eth_valid,
  output logic [47:0] eth_dst,
  output logic [47:0] eth_src,
  output logic [15:0] eth_type,
  output logic        ip_valid,
  output logic [3:0]  ip_ver,
  output logic [3:0]  ip_ihl,
  output logic [7:0]  ip_tos,
  output logic [15:0] ip_tlen,
  output logic [15:0] ip_id,
  output logic [2:0]  ip_flags,
  output logic [12:0] ip_frag,
  output logic [7:0]  ip_ttl,
  output logic [7:0]  ip_proto,
  output logic [15:0] ip_csum,
  output logic [31:0] ip_src,
  output logic [31:0] ip_dst,
  output logic        pay_valid,
  output logic [7:0]  pay_data,
  output logic        pay_eop
);
  localparam int IPW = IP_BYTES * 8;

  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;
  logic             pay_fire;
  logic [HDR_W-1:0] hdr;
  logic [IPW-1:0]   iph;

  hp_ctrl #(.ETYPE_IP(ETYPE_IP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .type_hi  (hdr[HDR_W-1-8*(ETH_BYTES-2) -: 8]),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .pay_fire (pay_fire),
    .done_q   (done),
    .acc_q    (res_accept),
    .err_q    (err_code),
    .ev_q     (eth_valid),
    .iv_q     (ip_valid)
  );

  hp_store u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (in_data),
    .hdr     (hdr)
  );

  hp_pass u_pass (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (pay_fire),
    .data      (in_data),
    .eop       (in_eop),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_eop   (pay_eop)
  );

  assign eth_dst  = hdr[HDR_W-1   -: 48];
  assign eth_src  = hdr[HDR_W-49  -: 48];
  assign eth_type = hdr[HDR_W-97  -: 16];
  assign iph      = hdr[IPW-1:0];
  assign ip_ver   = iph[IPW-1   -: 4];
  assign ip_ihl   = iph[IPW-5   -: 4];
  assign ip_tos   = iph[IPW-9   -: 8];
  assign ip_tlen  = iph[IPW-17  -: 16];
  assign ip_id    = iph[IPW-33  -: 16];
  assign ip_flags = iph[IPW-49  -: 3];
  assign ip_frag  = iph[IPW-52  -: 13];
  assign ip_ttl   = iph[IPW-65  -: 8];
  assign ip_proto = iph[IPW-73  -: 8];
  assign ip_csum  = iph[IPW-81  -: 16];
  assign ip_src   = iph[63:32];
  assign ip_dst   = iph[31:0];
endmodule

// File: rtl/hp_chk.sv
module hp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sop,
  input logic        in_eop,
  input logic        done,
  input logic        res_accept,
  input logic [1:0]  err_code,
  input logic        eth_valid,
  input logic        ip_valid,
  input logic [15:0] eth_type,
  input logic        pay_valid
);
  AST_ACCEPT_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_accept) |-> (err_code == 2'd0 && eth_valid && ip_valid)); // R3
  AST_IP_NEEDS_ETH: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid |-> (eth_valid && eth_type == 16'h0800)); // R3
  AST_REJECT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_accept) |-> (err_code != 2'd0 && !ip_valid)); // R4
  AST_SHORT_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd1) |-> $past(in_valid && in_eop)); // R5
  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd3); // R5
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_accept) && $stable(err_code))); // R6
  AST_SOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> (!ip_valid && !eth_valid)); // R7
  AST_PAY_AFTER_IP: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (ip_valid && $past(in_valid))); // R8
  AST_DONE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid)); // R9
endmodule

bind hdrparse_top hp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sop     (in_sop),
  .in_eop     (in_eop),
  .done       (done),
  .res_accept (res_accept),
  .err_code   (err_code),
  .eth_valid  (eth_valid),
  .ip_valid   (ip_valid),
  .eth_type   (eth_type),
  .pay_valid  (pay_valid)
);

// File: tb/hdrparse_top_tb_top.sv
module hdrparse_top_tb_top;
  typedef struct packed {
    logic         acc;
    logic [1:0]   err;
    logic         ev;
    logic         iv;
    logic [271:0] hdr;
  } exp_t;

  logic clk, rst_n, in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic done, res_accept, eth_valid, ip_valid, pay_valid, pay_eop;
  logic [1:0] err_code;
  logic [47:0] eth_dst, eth_src;
  logic [15:0] eth_type, ip_tlen, ip_id, ip_csum;
  logic [3:0] ip_ver, ip_ihl;
  logic [7:0] ip_tos, ip_ttl, ip_proto, pay_data;
  logic [2:0] ip_flags;
  logic [12:0] ip_frag;
  logic [31:0] ip_src, ip_dst;

  int n_tests = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_pay = 0;
  bit finished = 0;
  bit prev_done = 0;
  exp_t eq[$];
  string tq[$];
  logic [8:0] pq[$];
  logic [7:0] pkt [0:63];
  logic [271:0] last_hdr;

  hdrparse_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .done(done), .res_accept(res_accept),
    .err_code(err_code), .eth_valid(eth_valid), .eth_dst(eth_dst),
    .eth_src(eth_src), .eth_type(eth_type), .ip_valid(ip_valid),
    .ip_ver(ip_ver), .ip_ihl(ip_ihl), .ip_tos(ip_tos), .ip_tlen(ip_tlen),
    .ip_id(ip_id), .ip_flags(ip_flags), .ip_frag(ip_frag), .ip_ttl(ip_ttl),
    .ip_proto(ip_proto), .ip_csum(ip_csum), .ip_src(ip_src), .ip_dst(ip_dst),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_eop(pay_eop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse and each payload byte.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done && prev_done)
        chk(1'b0, "R6 done longer than one cycle", 64'(done), 64'd0);
      if (done) begin
        n_done++;
        if (eq.size() == 0) begin
          chk(1'b0, "R7/R9 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          string t;
          e = eq.pop_front();
          t = tq.pop_front();
          chk({res_accept, err_code} == {e.acc, e.err}, {t, " outcome"},
              64'({res_accept, err_code}), 64'({e.acc, e.err}));
          chk({eth_valid, ip_valid} == {e.ev, e.iv}, {t, " valid bits"},
              64'({eth_valid, ip_valid}), 64'({e.ev, e.iv}));
          if (e.ev) begin
            chk({eth_dst, eth_type} == {e.hdr[271:224], e.hdr[175:160]},
                "R2 dst/type", 64'({eth_dst, eth_type}),
                64'({e.hdr[271:224], e.hdr[175:160]}));
            chk(eth_src == e.hdr[223:176], "R2 src", 64'(eth_src),
                64'(e.hdr[223:176]));
          end
          if (e.iv) begin
            chk({ip_ver, ip_ihl, ip_tos, ip_tlen, ip_id} == e.hdr[159:112],
                {t, " ip word A"}, 64'({ip_ver, ip_ihl, ip_tos, ip_tlen, ip_id}),
                64'(e.hdr[159:112]));
            chk({ip_flags, ip_frag, ip_ttl, ip_proto, ip_csum} == e.hdr[111:64],
                {t, " ip word B"},
                64'({ip_flags, ip_frag, ip_ttl, ip_proto, ip_csum}),
                64'(e.hdr[111:64]));
            chk({ip_src, ip_dst} == e.hdr[63:0], {t, " ip addrs"},
                {ip_src, ip_dst}, e.hdr[63:0]);
          end
        end
      end
      if (pay_valid) begin
        n_pay++;
        if (pq.size() == 0) begin
          chk(1'b0, "R8 unexpected payload", 64'(pay_data), 64'd0);
        end else begin
          logic [8:0] p;
          p = pq.pop_front();
          chk({pay_eop, pay_data} == p, "R8 payload byte",
              64'({pay_eop, pay_data}), 64'(p));
        end
      end
      prev_done = done;
    end
  end

  // Driver: builds a packet, pushes expectations, then streams it.
  task automatic send(input int len, input logic [15:0] etype, input int seed,
                      input bit gaps, input bit with_eop, input string tag);
    exp_t e;
    for (int i = 0; i < 64; i++) pkt[i] = 8'(i * 37 + seed * 11 + 5);
    pkt[12] = etype[15:8];
    pkt[13] = etype[7:0];
    e.hdr = '0;
    for (int i = 0; i < 34; i++) e.hdr[271-8*i -: 8] = pkt[i];
    last_hdr = e.hdr;
    if (len < 14) begin
      e.acc = 0; e.err = 2'd1; e.ev = 0; e.iv = 0;
    end else if (etype != 16'h0800) begin
      e.acc = 0; e.err = 2'd2; e.ev = 1; e.iv = 0;
    end else if (len < 34) begin
      e.acc = 0; e.err = 2'd1; e.ev = 1; e.iv = 0;
    end else begin
      e.acc = 1; e.err = 2'd0; e.ev = 1; e.iv = 1;
      if (with_eop)
        for (int i = 34; i < len; i++) pq.push_back({(i == len - 1), pkt[i]});
    end
    if (with_eop) begin
      eq.push_back(e);
      tq.push_back(tag);
    end
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
      end
      @(negedge clk);
      in_valid = 1;
      in_data  = pkt[i];
      in_sop   = (i == 0);
      in_eop   = with_eop && (i == len - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0, "R1 done after reset", 64'(done), 0);
    chk(eth_valid == 0, "R1 eth_valid after reset", 64'(eth_valid), 0);
    chk(ip_valid == 0, "R1 ip_valid after reset", 64'(ip_valid), 0);
    chk(pay_valid == 0, "R1 pay_valid after reset", 64'(pay_valid), 0);

    send(40, 16'h0800, 1, 0, 1, "R3 ipv4 with payload");
    repeat (4) @(negedge clk);
    chk({ip_valid, ip_src} == {1'b1, last_hdr[63:32]}, "R6 record held",
        64'({ip_valid, ip_src}), 64'({1'b1, last_hdr[63:32]}));
    chk(done == 0, "R6 done low after pulse", 64'(done), 0);

    send(34, 16'h0800, 2, 0, 1, "R3 exact ipv4 no payload");
    send(42, 16'h0806, 3, 0, 1, "R4 other type");
    send(14, 16'h86dd, 4, 0, 1, "R4 type at last byte");
    send(10, 16'h0800, 5, 0, 1, "R5 short ethernet");
    send(20, 16'h0800, 6, 0, 1, "R5 short ipv4");
    send(14, 16'h0800, 7, 0, 1, "R5 ipv4 type then end");
    send(1, 16'h0800, 8, 0, 1, "R5 single byte");
    send(45, 16'h0800, 9, 1, 1, "R10 stalled ipv4");
    send(12, 16'h0800, 10, 1, 1, "R10 stalled short");

    begin
      int d0;
      d0 = n_done;
      send(20, 16'h0800, 11, 0, 0, "R7 abandoned");
      send(36, 16'h0800, 12, 0, 1, "R7 restart");
      chk(n_done == d0 + 1, "R7 one done for two starts", 64'(n_done),
          64'(d0 + 1));
    end

    begin
      int d0, p0;
      d0 = n_done; p0 = n_pay;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        in_valid = 1; in_data = 8'(i + 8'h40); in_sop = 0; in_eop = (i == 5);
      end
      @(negedge clk);
      in_valid = 0; in_eop = 0;
      repeat (3) @(negedge clk);
      chk(n_done == d0, "R9 stray bytes no done", 64'(n_done), 64'(d0));
      chk(n_pay == p0, "R9 stray bytes no payload", 64'(n_pay), 64'(p0));
    end

    repeat (4) @(negedge clk);
    chk(eq.size() == 0, "R3 all results seen", 64'(eq.size()), 0);
    chk(pq.size() == 0, "R8 all payload seen", 64'(pq.size()), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule